// File: doc/BRIEF.md
# Sixteen-bit Event Timer with Compare Reset

This block is a 16-bit up-counter that an 8-bit processor reaches through a small register window. The counter can advance on every core clock, or on rising edges of an external pin. Edges on the pin can pass through a two-stage synchronizer, or they can take a bypass that detects the edge directly on the raw pin. A prescaler divides the selected source by 1, 2, 4 or 8. When the count rolls over from FFFFh to 0000h, a sticky interrupt flag is set. Software clears the flag by writing it.

A compare unit holds a 16-bit reference value and a 4-bit mode field. When the mode selects the special event, a counter tick that arrives while the count equals the reference loads zero in place of the increment. The reference therefore acts as a period register. This clear never sets the rollover flag. A bus write to a count byte in that same cycle takes priority.

Two resets are provided. The power-on/brown-out reset clears the control register, which stops the counter. The general reset leaves the control register alone. Neither reset clears the count bytes.

Top module: `tmr16_unit`

## Requirements
- R1: While `por_n` is low, the control register (address 0) is cleared to 00h and the counter does not advance. After release it reads 00h and the count holds its value.
- R2: A pulse on `rst_n` alone leaves both the control register and the two count bytes unchanged.
- R3: With control bit 0 set and bit 1 clear, the count advances by one on every clock at 1:1 prescale. With bit 0 clear, the count holds.
- R4: Control bits 5:4 select the divide ratio: 0 for 1:1, 1 for 1:2, 2 for 1:4, 3 for 1:8. After n source ticks from a cleared prescaler, the count has advanced by floor(n / ratio).
- R5: With bit 1 set and bit 2 clear, a rising edge on `ext_clk_pin` raises the count by one at the third rising clock edge after the pin goes high. Each pulse counts once.
- R6: With bits 1 and 2 both set, a pin edge counts at the first clock edge. In this mode the compare clear is suppressed.
- R7: A tick at FFFFh wraps the count to 0000h and sets the flag, readable at address 6 bit 0 and on `irq_flag`. Writing 0 to address 6 clears the flag.
- R8: When the mode field (address 5, bits 3:0) is 1011b, a tick while the count equals the reference (address 4 high byte, address 3 low byte) loads 0000h, and `cmp_event` is high in that cycle.
- R9: A compare clear at FFFFh leaves the flag clear.
- R10: A write to a count byte in the same cycle as a compare clear wins. The written byte is loaded and the other byte keeps its value.
- R11: A write to either count byte clears the prescaler. At 1:8 the next increment follows exactly 8 ticks after the write.
- R12: The register map reads back as follows: 0 control (bits 5:4, 2, 1, 0; other bits read 0), 1 count low, 2 count high, 3 reference low, 4 reference high, 5 mode in bits 3:0, 6 flag in bit 0, 7 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on/brown-out reset, active low, asynchronous |
| rst_n | input | 1 | General reset, active low, asynchronous |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ext_clk_pin | input | 1 | External count input |
| irq_flag | output | 1 | Sticky rollover flag |
| cmp_event | output | 1 | High in the cycle a compare clear takes effect |

## Verification
Two collisions can fall in a single clock. A compare clear can meet a bus write to the low count byte. A compare clear can also coincide with the FFFFh rollover when the reference is FFFFh.

The bench provokes the first collision by waiting until `cmp_event` is seen high and then issuing the write on the very next edge. It then expects the written byte, followed by a plain increment. It provokes the second by loading FFFEh with a reference of FFFFh. It expects zero in the count with the flag still clear, whereas an ordinary wrap would have set the flag.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_CNTL = 3'd1,
    RA_CNTH = 3'd2,
    RA_REFL = 3'd3,
    RA_REFH = 3'd4,
    RA_MODE = 3'd5,
    RA_FLAG = 3'd6,
    RA_NONE = 3'd7
  } reg_addr_e;

  localparam logic [3:0] MODE_CLEAR_ON_MATCH = 4'b1011;

  typedef struct packed {
    logic [1:0] ps;
    logic       nosync;
    logic       ext;
    logic       run;
  } ctrl_t;

  // last prescaler state before a tick is passed on: ratio minus one
  function automatic int unsigned ps_last(int unsigned sel);
    return (32'd1 << sel) - 32'd1;
  endfunction

endpackage

// File: rtl/tmr16_edge.sv
module tmr16_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic bypass,
  output logic edge_o
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] chain_q;
  logic         hist_q;
  logic         raw_q;
  logic         sync_edge;
  logic         raw_edge;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[TOP-1:0], pin};
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= pin;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hist_q <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      hist_q <= chain_q[TOP];
      raw_q  <= pin;
    end

  assign sync_edge = chain_q[TOP] & ~hist_q;
  assign raw_edge  = pin & ~raw_q;
  assign edge_o    = bypass ? raw_edge : sync_edge;

  AST_SYNC_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_edge |=> !sync_edge); // R5

endmodule

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            tick_in,
  input  logic [PS_W-1:0] sel,
  output logic            tick_out
);
  import tmr16_pkg::*;
  localparam int PRE_W = (1 << PS_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic             at_last;

  assign at_last  = (pre_q == PRE_W'(ps_last(32'(sel))));
  assign tick_out = tick_in & at_last;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       pre_q <= '0;
    else if (clr)     pre_q <= '0;
    else if (tick_in) pre_q <= at_last ? '0 : pre_q + 1'b1;

  AST_PRESCALE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre_q == '0)); // R11

endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit #(
  parameter int BYTE_W      = 8,
  parameter int MODE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic              bus_we,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              ext_clk_pin,
  output logic              irq_flag,
  output logic              cmp_event
);
  import tmr16_pkg::*;
  localparam int CNT_W = 2 * BYTE_W;

  function automatic logic [CNT_W-1:0] count_next(
    input logic [CNT_W-1:0]  cur,
    input logic              wl,
    input logic              wh,
    input logic [BYTE_W-1:0] d,
    input logic              clr,
    input logic              inc
  );
    logic [CNT_W-1:0] r;
    r = cur;
    if (wl || wh) begin
      if (wl) r[BYTE_W-1:0]     = d;
      if (wh) r[CNT_W-1:BYTE_W] = d;
    end else if (clr) begin
      r = '0;
    end else if (inc) begin
      r = cur + 1'b1;
    end
    return r;
  endfunction

  logic              any_rst_n;
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] ref_lo_q, ref_hi_q;
  logic [MODE_W-1:0] mode_q;
  logic              flag_q;

  logic wr_ctrl, wr_lo, wr_hi, wr_rlo, wr_rhi, wr_mode, wr_flag, cnt_wr;
  logic ext_edge, src_tick, cnt_tick, async_mode, match, sevt_fire, wrap;

  assign any_rst_n = rst_n & por_n;

  // bus decode
  assign wr_ctrl = bus_we && (reg_addr_e'(bus_addr) == RA_CTRL);
  assign wr_lo   = bus_we && (reg_addr_e'(bus_addr) == RA_CNTL);
  assign wr_hi   = bus_we && (reg_addr_e'(bus_addr) == RA_CNTH);
  assign wr_rlo  = bus_we && (reg_addr_e'(bus_addr) == RA_REFL);
  assign wr_rhi  = bus_we && (reg_addr_e'(bus_addr) == RA_REFH);
  assign wr_mode = bus_we && (reg_addr_e'(bus_addr) == RA_MODE);
  assign wr_flag = bus_we && (reg_addr_e'(bus_addr) == RA_FLAG);
  assign cnt_wr  = wr_lo | wr_hi;

  // clock source front end
  tmr16_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (any_rst_n),
    .pin    (ext_clk_pin),
    .bypass (ctrl_q.nosync),
    .edge_o (ext_edge)
  );

  assign src_tick = ctrl_q.run & (ctrl_q.ext ? ext_edge : 1'b1);

  tmr16_prescale #(.PS_W(2)) u_pre (
    .clk      (clk),
    .rst_n    (any_rst_n),
    .clr      (cnt_wr),
    .tick_in  (src_tick),
    .sel      (ctrl_q.ps),
    .tick_out (cnt_tick)
  );

  // compare unit
  assign async_mode = ctrl_q.ext & ctrl_q.nosync;
  assign match      = (cnt_q == {ref_hi_q, ref_lo_q});
  assign sevt_fire  = cnt_tick & match & (mode_q == MODE_CLEAR_ON_MATCH) & ~async_mode;
  assign wrap       = cnt_tick & (&cnt_q) & ~sevt_fire & ~cnt_wr;
  assign cmp_event  = sevt_fire & ~cnt_wr;

  // control register: only power-on / brown-out clears it
  always_ff @(posedge clk or negedge por_n)
    if (!por_n) ctrl_q <= '0;
    else if (rst_n && wr_ctrl)
      ctrl_q <= '{ps: bus_wdata[5:4], nosync: bus_wdata[2],
                  ext: bus_wdata[1], run: bus_wdata[0]};

  // count bytes: no reset, held while any reset is active
  always_ff @(posedge clk)
    if (any_rst_n)
      cnt_q <= count_next(cnt_q, wr_lo, wr_hi, bus_wdata, sevt_fire, cnt_tick);

  always_ff @(posedge clk or negedge any_rst_n)
    if (!any_rst_n) begin
      ref_lo_q <= '0;
      ref_hi_q <= '0;
      mode_q   <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_rlo)  ref_lo_q <= bus_wdata;
      if (wr_rhi)  ref_hi_q <= bus_wdata;
      if (wr_mode) mode_q   <= bus_wdata[MODE_W-1:0];
      if (wrap)         flag_q <= 1'b1;
      else if (wr_flag) flag_q <= bus_wdata[0];
    end

  assign irq_flag = flag_q;

  always_comb begin
    unique case (reg_addr_e'(bus_addr))
      RA_CTRL: bus_rdata = BYTE_W'({ctrl_q.ps, 1'b0, ctrl_q.nosync, ctrl_q.ext, ctrl_q.run});
      RA_CNTL: bus_rdata = cnt_q[BYTE_W-1:0];
      RA_CNTH: bus_rdata = cnt_q[CNT_W-1:BYTE_W];
      RA_REFL: bus_rdata = ref_lo_q;
      RA_REFH: bus_rdata = ref_hi_q;
      RA_MODE: bus_rdata = BYTE_W'(mode_q);
      RA_FLAG: bus_rdata = BYTE_W'(flag_q);
      default: bus_rdata = '0;
    endcase
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!any_rst_n)
    (!ctrl_q.run && !cnt_wr) |=> $stable(cnt_q)); // R3
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!any_rst_n)
    wrap |=> irq_flag); // R7
  AST_EVT_CLEARS: assert property (@(posedge clk) disable iff (!any_rst_n)
    cmp_event |=> (cnt_q == '0)); // R8
  AST_ASYNC_NO_EVT: assert property (@(posedge clk) disable iff (!any_rst_n)
    async_mode |-> !cmp_event); // R6
  AST_EVT_NO_FLAG: assert property (@(posedge clk) disable iff (!any_rst_n)
    (sevt_fire && !irq_flag && !wr_flag) |=> !irq_flag); // R9
  AST_WRITE_BEATS_EVT: assert property (@(posedge clk) disable iff (!any_rst_n)
    (sevt_fire && wr_lo) |=> (cnt_q[BYTE_W-1:0] == $past(bus_wdata))); // R10

endmodule

// File: tb/tmr16_unit_test.sv
module tmr16_unit_test;
  logic       clk = 1'b0;
  logic       por_n, rst_n, bus_we, ext_clk_pin;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       irq_flag, cmp_event;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  tmr16_unit uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk_pin(ext_clk_pin), .irq_flag(irq_flag), .cmp_event(cmp_event)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  task automatic rd16(output int v);
    int lo, hi;
    rd(3'd1, lo);
    rd(3'd2, hi);
    v = (hi << 8) | lo;
  endtask

  task automatic load(int value);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'(value >> 8));
    wr(3'd1, 8'(value));
  endtask

  task automatic t_reset_state;
    int v;
    rd(3'd0, v); check("R1 ctrl after power-on", v, 0);
    rd(3'd6, v); check("R7 flag after power-on", v, 0);
  endtask

  task automatic t_internal;
    int v;
    load(16'h0010);
    wr(3'd0, 8'h01);
    step(20);
    rd16(v); check("R3 count 1:1", v, 16'h0024);
    wr(3'd0, 8'h00);
    step(5);
    rd16(v); check("R3 hold when stopped", v, 16'h0025);
  endtask

  task automatic t_prescale;
    int v;
    for (int ps = 1; ps < 4; ps++) begin
      wr(3'd0, 8'(ps << 4));
      wr(3'd2, 8'h00);
      wr(3'd1, 8'h00);
      wr(3'd0, 8'((ps << 4) | 1));
      step(13);
      rd16(v); check("R4 prescale ratio", v, 13 >> ps);
    end
  endtask

  task automatic t_prescale_clear;
    int v;
    wr(3'd0, 8'h30);
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h31);
    step(3);
    wr(3'd1, 8'h50);
    step(7);
    rd16(v); check("R11 no tick before 8", v, 16'h0050);
    step(1);
    rd16(v); check("R11 tick at 8", v, 16'h0051);
  endtask

  task automatic t_overflow;
    int v;
    load(16'hFFFE);
    wr(3'd5, 8'h00);
    wr(3'd6, 8'h00);
    wr(3'd0, 8'h01);
    step(1);
    check("R7 flag before wrap", int'(irq_flag), 0);
    step(1);
    rd16(v); check("R7 wrap to zero", v, 0);
    check("R7 flag set", int'(irq_flag), 1);
    wr(3'd6, 8'h00);
    rd(3'd6, v); check("R7 flag cleared by write", v, 0);
  endtask

  task automatic set_ref(int value);
    wr(3'd4, 8'(value >> 8));
    wr(3'd3, 8'(value));
    wr(3'd5, 8'h0B);
  endtask

  task automatic t_compare;
    int v;
    load(0);
    set_ref(5);
    wr(3'd0, 8'h01);
    step(5);
    rd16(v); check("R8 count at reference", v, 5);
    check("R8 event high", int'(cmp_event), 1);
    step(1);
    rd16(v); check("R8 cleared on match", v, 0);
    check("R8 event low", int'(cmp_event), 0);
    step(5);
    rd16(v); check("R8 second period", v, 5);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_trig_at_top;
    int v;
    load(16'hFFFE);
    wr(3'd6, 8'h00);
    set_ref(16'hFFFF);
    wr(3'd0, 8'h01);
    step(1);
    check("R9 event at FFFF", int'(cmp_event), 1);
    step(1);
    rd16(v); check("R9 cleared to zero", v, 0);
    check("R9 flag stays clear", int'(irq_flag), 0);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_write_wins;
    int v;
    load(0);
    set_ref(5);
    wr(3'd0, 8'h01);
    step(5);
    check("R10 event pending", int'(cmp_event), 1);
    wr(3'd1, 8'h40);
    rd16(v); check("R10 write wins", v, 16'h0040);
    step(1);
    rd16(v); check("R10 counts on", v, 16'h0041);
    wr(3'd0, 8'h00);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      ext_clk_pin = 1'b1; step(3);
      ext_clk_pin = 1'b0; step(3);
    end
  endtask

  task automatic t_sync_ext;
    int v;
    wr(3'd5, 8'h00);
    load(0);
    wr(3'd0, 8'h03);
    step(3);
    ext_clk_pin = 1'b1;
    step(2);
    rd16(v); check("R5 not yet after 2 edges", v, 0);
    step(1);
    rd16(v); check("R5 counted at edge 3", v, 1);
    ext_clk_pin = 1'b0;
    step(4);
    pulses(3);
    step(4);
    rd16(v); check("R5 pulses counted once", v, 4);
  endtask

  task automatic t_async_ext;
    int v;
    load(0);
    set_ref(2);
    wr(3'd0, 8'h07);
    step(2);
    ext_clk_pin = 1'b1;
    step(1);
    rd16(v); check("R6 counted at first edge", v, 1);
    ext_clk_pin = 1'b0;
    step(2);
    pulses(3);
    rd16(v); check("R6 no compare clear", v, 4);
    wr(3'd0, 8'h00);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_resets;
    int v;
    wr(3'd0, 8'h30);
    wr(3'd2, 8'h12);
    wr(3'd1, 8'h34);
    rst_n = 1'b0; step(2); rst_n = 1'b1; step(1);
    rd(3'd0, v); check("R2 ctrl kept", v, 8'h30);
    rd16(v); check("R2 count kept", v, 16'h1234);
    wr(3'd0, 8'h01);
    por_n = 1'b0; step(2); por_n = 1'b1; step(3);
    rd(3'd0, v); check("R1 ctrl cleared", v, 0);
    rd16(v); check("R1 count kept and stopped", v, 16'h1234);
  endtask

  task automatic t_readback;
    int v;
    wr(3'd3, 8'hA5);
    rd(3'd3, v); check("R12 reference low", v, 8'hA5);
    wr(3'd4, 8'h5A);
    rd(3'd4, v); check("R12 reference high", v, 8'h5A);
    wr(3'd5, 8'hFB);
    rd(3'd5, v); check("R12 mode masked", v, 8'h0B);
    wr(3'd0, 8'hFE);
    rd(3'd0, v); check("R12 ctrl masked", v, 8'h36);
    rd(3'd7, v); check("R12 unused address", v, 0);
    wr(3'd0, 8'h00);
    wr(3'd5, 8'h00);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    por_n = 1'b0; rst_n = 1'b0; bus_we = 1'b0; bus_addr = 3'd0;
    bus_wdata = 8'h00; ext_clk_pin = 1'b0;
    step(3);
    por_n = 1'b1; rst_n = 1'b1;
    step(1);
    t_reset_state();
    t_internal();
    t_prescale();
    t_prescale_clear();
    t_overflow();
    t_compare();
    t_trig_at_top();
    t_write_wins();
    t_sync_ext();
    t_async_ext();
    t_resets();
    t_readback();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end
endmodule